// File: doc/BRIEF.md
# Repeat-Mode Transfer Sequencer

This block moves one data unit from a source address to a destination address each time a transfer request arrives. A descriptor is kept in internal registers. It holds both addresses, an 8-bit working count, an 8-bit reload count, a unit size, a step mode for each address, a selector that picks which side is the repeat area, an interrupt-select bit and a write-back disable bit. For every request the sequencer makes one read and then one write on a valid/ready memory port. It then updates the descriptor and presents the new values on a write-back strobe.

The transfer never terminates. When the working count has run down to one, the next transfer reloads the count and returns the repeat-side address to the value it had when the descriptor was loaded. The other address keeps stepping across block boundaries. Because the count never reaches zero, the only interrupt the block raises is the per-transfer one, and only when the descriptor asks for it.

Its states are IDLE, RD_REQ, RD_WAIT, WR_REQ and WBACK. A request taken in IDLE moves to RD_REQ. The read handshake moves RD_REQ to RD_WAIT. Returning read data moves RD_WAIT to WR_REQ. The write handshake moves WR_REQ to WBACK, and WBACK always goes back to IDLE one cycle later.

Top module: `rpt_xfer_seq`

## Requirements
- R1: Each request issues exactly one read (mem_we=0) at the source address and then one write (mem_we=1) at the destination address. Both carry mem_size equal to the size code, which means 00 = 1 byte, 01 = 2 bytes, 10 = 4 bytes, and 11 is handled as 4 bytes.
- R2: With cfg_rpt_src=1 the source address is the repeat area. With cfg_rpt_src=0 the destination address is the repeat area.
- R3: A count value n gives blocks of n transfers, and a count of 00h gives blocks of 256 transfers.
- R4: After a transfer whose working count was not 1, the working count drops by one, the repeat-side address steps, and the reload count is unchanged.
- R5: After a transfer whose working count was 1, the working count is reloaded from the reload count, and the repeat-side address returns to the value captured when the descriptor was loaded.
- R6: Each address has a step mode: 10 increments, 11 decrements, and 00 or 01 holds it fixed. The step equals the unit size in bytes. The non-repeat side follows its mode on every transfer, whatever the block position.
- R7: irq pulses together with done on every transfer when cfg_irq_each=1, and never pulses when cfg_irq_each=0.
- R8: wb_valid pulses with done unless cfg_wb_off=1, in which case it never pulses. wb_src_en and wb_dst_en are high with wb_valid only for an address whose step mode is not fixed. wb_src_addr, wb_dst_addr, wb_count and wb_reload show the updated descriptor.
- R9: req is taken only in IDLE, and a req raised while busy is ignored. busy is high from the cycle after acceptance through the write-back cycle. done is a one-cycle pulse in the last busy cycle. Reset returns the block to idle.
- R10: While mem_valid is high and mem_ready is low, mem_valid, mem_we and mem_addr hold. The read data is kept and driven as mem_wdata until the write is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | Loads the descriptor (taken only when idle) |
| cfg_src_addr | input | AW | Initial source address |
| cfg_dst_addr | input | AW | Initial destination address |
| cfg_count | input | CW | Block length, loaded into the working and reload counts |
| cfg_size | input | 2 | Unit size code |
| cfg_rpt_src | input | 1 | 1: source is the repeat area, 0: destination is the repeat area |
| cfg_src_step | input | 2 | Source step mode |
| cfg_dst_step | input | 2 | Destination step mode |
| cfg_irq_each | input | 1 | Interrupt after every transfer |
| cfg_wb_off | input | 1 | Disables descriptor write-back |
| req | input | 1 | Transfer request |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | End-of-request pulse |
| irq | output | 1 | CPU interrupt pulse |
| mem_valid | output | 1 | Memory command valid |
| mem_ready | input | 1 | Memory command accepted |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Memory address |
| mem_size | output | 2 | Unit size code |
| mem_wdata | output | DW | Write data |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | DW | Read data |
| wb_valid | output | 1 | Descriptor write-back strobe |
| wb_src_en | output | 1 | Source address is written back |
| wb_dst_en | output | 1 | Destination address is written back |
| wb_src_addr | output | AW | Updated source address |
| wb_dst_addr | output | AW | Updated destination address |
| wb_count | output | CW | Updated working count |
| wb_reload | output | CW | Reload count |

## Verification
A table of descriptors runs the main function. Across the table the repeat area is placed on each side, all three unit sizes and the reserved size code appear, and the step modes cover increment, decrement, fixed and the reserved fixed code. Block lengths of 1, 2, 3, 4 and 256 are used, and each entry runs past at least one block end. That separates the decrement path from the reload path and shows that the repeat side snaps back while the other side keeps moving. Some entries stall the memory handshake, raise a request while busy, turn on the per-transfer interrupt or disable write-back. Each address the block issues and each write-back field is compared against a model built from the rules above.

// File: rtl/rpt_xfer_pkg.sv
package rpt_xfer_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RD_REQ,
        S_RD_WAIT,
        S_WR_REQ,
        S_WBACK
    } seq_state_t;

    localparam logic [1:0] STEP_INC = 2'b10;
    localparam logic [1:0] STEP_DEC = 2'b11;

    function automatic logic [3:0] unit_bytes(input logic [1:0] sz);
        unique case (sz)
            2'b00:   return 4'd1;
            2'b01:   return 4'd2;
            default: return 4'd4;
        endcase
    endfunction

    function automatic logic step_moves(input logic [1:0] mode);
        return mode[1];
    endfunction

endpackage

// File: rtl/rpt_addr_reg.sv
module rpt_addr_reg
    import rpt_xfer_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_addr,
    input  logic          advance,
    input  logic          restore,
    input  logic [1:0]    mode,
    input  logic [1:0]    size,
    output logic [AW-1:0] addr
);

    logic [AW-1:0] shadow_q;
    logic [AW-1:0] step_amt;
    logic [AW-1:0] addr_next;

    assign step_amt = AW'(unit_bytes(size));

    always_comb begin
        unique case (mode)
            STEP_INC: addr_next = addr + step_amt;
            STEP_DEC: addr_next = addr - step_amt;
            default:  addr_next = addr;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr     <= '0;
            shadow_q <= '0;
        end else if (load) begin
            addr     <= load_addr;
            shadow_q <= load_addr;
        end else if (advance) begin
            addr <= restore ? shadow_q : addr_next;
        end
    end

endmodule

// File: rtl/rpt_block_count.sv
module rpt_block_count #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          advance,
    output logic [CW-1:0] work,
    output logic [CW-1:0] reload,
    output logic          last
);

    localparam logic [CW-1:0] ONE = CW'(1);

    assign last = (work == ONE);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            work   <= '0;
            reload <= '0;
        end else if (load) begin
            work   <= load_val;
            reload <= load_val;
        end else if (advance) begin
            work <= last ? reload : work - ONE;
        end
    end

endmodule

// File: rtl/rpt_seq_fsm.sv
module rpt_seq_fsm
    import rpt_xfer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic mem_ready,
    input  logic mem_rvalid,
    output logic mem_valid,
    output logic mem_we,
    output logic capture,
    output logic advance,
    output logic wb_phase,
    output logic busy
);

    seq_state_t state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:    if (req)        state_nx = S_RD_REQ;
            S_RD_REQ:  if (mem_ready)  state_nx = S_RD_WAIT;
            S_RD_WAIT: if (mem_rvalid) state_nx = S_WR_REQ;
            S_WR_REQ:  if (mem_ready)  state_nx = S_WBACK;
            S_WBACK:                   state_nx = S_IDLE;
            default:                   state_nx = S_IDLE;
        endcase
    end

    always_comb begin
        mem_valid = 1'b0;
        mem_we    = 1'b0;
        capture   = 1'b0;
        advance   = 1'b0;
        wb_phase  = 1'b0;
        busy      = 1'b1;
        unique case (state)
            S_IDLE:    busy = 1'b0;
            S_RD_REQ:  mem_valid = 1'b1;
            S_RD_WAIT: capture = mem_rvalid;
            S_WR_REQ: begin
                mem_valid = 1'b1;
                mem_we    = 1'b1;
                advance   = mem_ready;
            end
            S_WBACK:   wb_phase = 1'b1;
            default:   busy = 1'b0;
        endcase
    end

endmodule

// File: rtl/rpt_xfer_seq.sv
module rpt_xfer_seq
    import rpt_xfer_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_load,
    input  logic [AW-1:0] cfg_src_addr,
    input  logic [AW-1:0] cfg_dst_addr,
    input  logic [CW-1:0] cfg_count,
    input  logic [1:0]    cfg_size,
    input  logic          cfg_rpt_src,
    input  logic [1:0]    cfg_src_step,
    input  logic [1:0]    cfg_dst_step,
    input  logic          cfg_irq_each,
    input  logic          cfg_wb_off,
    input  logic          req,
    output logic          busy,
    output logic          done,
    output logic          irq,
    output logic          mem_valid,
    input  logic          mem_ready,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [1:0]    mem_size,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_rvalid,
    input  logic [DW-1:0] mem_rdata,
    output logic          wb_valid,
    output logic          wb_src_en,
    output logic          wb_dst_en,
    output logic [AW-1:0] wb_src_addr,
    output logic [AW-1:0] wb_dst_addr,
    output logic [CW-1:0] wb_count,
    output logic [CW-1:0] wb_reload
);

    localparam int NSIDE = 2;   // 0: source, 1: destination

    logic          load_ok;
    logic          capture, advance, wb_phase;
    logic          blk_last;
    logic [1:0]    size_q;
    logic          rpt_src_q, irq_each_q, wb_off_q;
    logic [1:0]    step_q  [NSIDE];
    logic [AW-1:0] side_addr [NSIDE];
    logic [AW-1:0] side_init [NSIDE];
    logic [1:0]    side_step [NSIDE];
    logic [DW-1:0] data_q;

    assign load_ok = cfg_load && !busy;
    assign side_init[0] = cfg_src_addr;
    assign side_init[1] = cfg_dst_addr;
    assign side_step[0] = cfg_src_step;
    assign side_step[1] = cfg_dst_step;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            size_q     <= '0;
            rpt_src_q  <= 1'b0;
            irq_each_q <= 1'b0;
            wb_off_q   <= 1'b0;
        end else if (load_ok) begin
            size_q     <= cfg_size;
            rpt_src_q  <= cfg_rpt_src;
            irq_each_q <= cfg_irq_each;
            wb_off_q   <= cfg_wb_off;
        end
    end

    rpt_seq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (req),
        .mem_ready  (mem_ready),
        .mem_rvalid (mem_rvalid),
        .mem_valid  (mem_valid),
        .mem_we     (mem_we),
        .capture    (capture),
        .advance    (advance),
        .wb_phase   (wb_phase),
        .busy       (busy)
    );

    rpt_block_count #(.CW(CW)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_ok),
        .load_val (cfg_count),
        .advance  (advance),
        .work     (wb_count),
        .reload   (wb_reload),
        .last     (blk_last)
    );

    for (genvar s = 0; s < NSIDE; s++) begin : g_side
        logic is_rpt;
        assign is_rpt = (s == 0) ? rpt_src_q : !rpt_src_q;

        always_ff @(posedge clk) begin
            if (!rst_n)       step_q[s] <= '0;
            else if (load_ok) step_q[s] <= side_step[s];
        end

        rpt_addr_reg #(.AW(AW)) u_addr (
            .clk       (clk),
            .rst_n     (rst_n),
            .load      (load_ok),
            .load_addr (side_init[s]),
            .advance   (advance),
            .restore   (is_rpt && blk_last),
            .mode      (step_q[s]),
            .size      (size_q),
            .addr      (side_addr[s])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       data_q <= '0;
        else if (capture) data_q <= mem_rdata;
    end

    assign mem_addr    = mem_we ? side_addr[1] : side_addr[0];
    assign mem_size    = size_q;
    assign mem_wdata   = data_q;
    assign done        = wb_phase;
    assign irq         = wb_phase && irq_each_q;
    assign wb_valid    = wb_phase && !wb_off_q;
    assign wb_src_en   = wb_valid && step_moves(step_q[0]);
    assign wb_dst_en   = wb_valid && step_moves(step_q[1]);
    assign wb_src_addr = side_addr[0];
    assign wb_dst_addr = side_addr[1];

endmodule

// File: rtl/rpt_xfer_seq_chk.sv
module rpt_xfer_seq_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req,
    input logic          busy,
    input logic          done,
    input logic          irq,
    input logic          mem_valid,
    input logic          mem_ready,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic          wb_valid,
    input logic          wb_src_en,
    input logic          wb_dst_en
);

    assert_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req) |=> busy);

    assert_done_in_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    assert_done_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    assert_cmd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_we) && $stable(mem_addr)));

    assert_irq_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> done);

    assert_wb_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> done);

    assert_wb_enables_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_src_en || wb_dst_en) |-> wb_valid);

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_valid);

endmodule

bind rpt_xfer_seq rpt_xfer_seq_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .busy      (busy),
    .done      (done),
    .irq       (irq),
    .mem_valid (mem_valid),
    .mem_ready (mem_ready),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .wb_valid  (wb_valid),
    .wb_src_en (wb_src_en),
    .wb_dst_en (wb_dst_en)
);

// File: tb/rpt_xfer_seq_tb.sv
`timescale 1ns/1ps
module rpt_xfer_seq_tb;

    localparam int AW = 32;
    localparam int DW = 32;
    localparam int CW = 8;

    typedef struct packed {
        logic [31:0] src;
        logic [31:0] dst;
        logic [7:0]  cnt;
        logic [1:0]  size;
        logic        rpt_src;
        logic [1:0]  sm;
        logic [1:0]  dm;
        logic        irq;
        logic        wbd;
        logic [1:0]  stall;
        logic [9:0]  nreq;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{32'h0000_1000, 32'h0000_2000, 8'd3, 2'b00, 1'b1, 2'b10, 2'b10, 1'b0, 1'b0, 2'd0, 10'd7},
        '{32'h0000_3000, 32'h0000_4000, 8'd2, 2'b01, 1'b0, 2'b11, 2'b10, 1'b1, 1'b0, 2'd1, 10'd5},
        '{32'h0000_5000, 32'h0000_6000, 8'd1, 2'b10, 1'b1, 2'b10, 2'b00, 1'b0, 1'b1, 2'd0, 10'd3},
        '{32'h0000_7000, 32'h0000_8000, 8'd0, 2'b00, 1'b0, 2'b00, 2'b10, 1'b0, 1'b0, 2'd0, 10'd258},
        '{32'h0000_9000, 32'h0000_A000, 8'd4, 2'b10, 1'b0, 2'b10, 2'b11, 1'b1, 1'b0, 2'd2, 10'd6},
        '{32'h0000_B000, 32'h0000_C000, 8'd2, 2'b11, 1'b1, 2'b01, 2'b10, 1'b0, 1'b0, 2'd0, 10'd3}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_load = 1'b0;
    logic [AW-1:0] cfg_src_addr = '0, cfg_dst_addr = '0;
    logic [CW-1:0] cfg_count = '0;
    logic [1:0]    cfg_size = '0;
    logic          cfg_rpt_src = 1'b0;
    logic [1:0]    cfg_src_step = '0, cfg_dst_step = '0;
    logic          cfg_irq_each = 1'b0, cfg_wb_off = 1'b0;
    logic          req = 1'b0;
    logic          busy, done, irq;
    logic          mem_valid, mem_we;
    logic          mem_ready = 1'b0;
    logic [AW-1:0] mem_addr;
    logic [1:0]    mem_size;
    logic [DW-1:0] mem_wdata;
    logic          mem_rvalid = 1'b0;
    logic [DW-1:0] mem_rdata = '0;
    logic          wb_valid, wb_src_en, wb_dst_en;
    logic [AW-1:0] wb_src_addr, wb_dst_addr;
    logic [CW-1:0] wb_count, wb_reload;

    always #2 clk = ~clk;

    rpt_xfer_seq #(.AW(AW), .DW(DW), .CW(CW)) u_dut (.*);

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    // reference descriptor
    logic [31:0] es, ed, sh_s, sh_d;
    logic [7:0]  ec, er;
    vec_t        cv;

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    function automatic logic [31:0] stepped(input logic [31:0] a, input logic [1:0] m,
                                            input logic [1:0] sz);
        logic [31:0] b;
        b = (sz == 2'b00) ? 32'd1 : (sz == 2'b01) ? 32'd2 : 32'd4;
        if (m == 2'b10)      return a + b;
        else if (m == 2'b11) return a - b;
        else                 return a;
    endfunction

    task automatic load_desc(input vec_t v);
        @(negedge clk);
        cfg_load = 1'b1;
        cfg_src_addr = v.src; cfg_dst_addr = v.dst; cfg_count = v.cnt;
        cfg_size = v.size; cfg_rpt_src = v.rpt_src;
        cfg_src_step = v.sm; cfg_dst_step = v.dm;
        cfg_irq_each = v.irq; cfg_wb_off = v.wbd;
        @(negedge clk);
        cfg_load = 1'b0;
        cv = v; es = v.src; ed = v.dst; sh_s = v.src; sh_d = v.dst;
        ec = v.cnt; er = v.cnt;
    endtask

    task automatic xfer(input int stall, input bit poke);
        logic [31:0] rd;
        bit          last;
        string       tag_s, tag_d, tag_c;
        last  = (ec == 8'd1);
        tag_s = cv.rpt_src ? "R2/R4/R5" : "R6";
        tag_d = cv.rpt_src ? "R6" : "R2/R4/R5";
        tag_c = (er == 8'd0) ? "R3" : (last ? "R5" : "R4");
        @(negedge clk) req = 1'b1;
        @(negedge clk) req = 1'b0;
        chk(mem_valid && !mem_we, "R1", "read issued", {30'd0, mem_valid, mem_we}, 32'd2);
        chk(mem_addr == es, tag_s, "read address", mem_addr, es);
        chk(mem_size == cv.size, "R1", "read size", {30'd0, mem_size}, {30'd0, cv.size});
        for (int i = 0; i < stall; i++) begin
            @(negedge clk);
            chk(mem_valid && !mem_we && mem_addr == es, "R10", "read held in stall", mem_addr, es);
        end
        mem_ready = 1'b1;
        @(negedge clk) mem_ready = 1'b0;
        if (poke) req = 1'b1;
        rd = es ^ 32'hC3C3_0F0F;
        mem_rvalid = 1'b1; mem_rdata = rd;
        @(negedge clk) mem_rvalid = 1'b0; mem_rdata = 32'hDEAD_BEEF;
        req = 1'b0;
        chk(mem_valid && mem_we, "R1", "write issued", {30'd0, mem_valid, mem_we}, 32'd3);
        chk(mem_addr == ed, tag_d, "write address", mem_addr, ed);
        chk(mem_wdata == rd, "R10", "write data", mem_wdata, rd);
        for (int i = 0; i < stall; i++) begin
            @(negedge clk);
            chk(mem_valid && mem_we && mem_addr == ed && mem_wdata == rd, "R10",
                "write held in stall", mem_wdata, rd);
        end
        mem_ready = 1'b1;
        @(negedge clk) mem_ready = 1'b0;
        // reference update
        if (last) begin
            ec = er;
            if (cv.rpt_src) begin es = sh_s; ed = stepped(ed, cv.dm, cv.size); end
            else begin ed = sh_d; es = stepped(es, cv.sm, cv.size); end
        end else begin
            ec = ec - 8'd1;
            es = stepped(es, cv.sm, cv.size);
            ed = stepped(ed, cv.dm, cv.size);
        end
        chk(done && busy, "R9", "done in last busy cycle", {30'd0, done, busy}, 32'd3);
        chk(irq == cv.irq, "R7", "irq", {31'd0, irq}, {31'd0, cv.irq});
        chk(wb_valid == !cv.wbd, "R8", "wb strobe", {31'd0, wb_valid}, {31'd0, !cv.wbd});
        if (!cv.wbd) begin
            chk(wb_src_en == cv.sm[1], "R8", "src wb enable", {31'd0, wb_src_en}, {31'd0, cv.sm[1]});
            chk(wb_dst_en == cv.dm[1], "R8", "dst wb enable", {31'd0, wb_dst_en}, {31'd0, cv.dm[1]});
            chk(wb_src_addr == es, tag_s, "wb src", wb_src_addr, es);
            chk(wb_dst_addr == ed, tag_d, "wb dst", wb_dst_addr, ed);
            chk(wb_count == ec, tag_c, "wb count", {24'd0, wb_count}, {24'd0, ec});
            chk(wb_reload == er, "R4", "wb reload", {24'd0, wb_reload}, {24'd0, er});
        end
        @(negedge clk);
        chk(!busy && !done, "R9", "idle after request", {30'd0, busy, done}, 32'd0);
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !irq && !mem_valid && !wb_valid, "R9", "reset state",
            {27'd0, busy, done, irq, mem_valid, wb_valid}, 32'd0);

        for (int v = 0; v < 6; v++) begin
            load_desc(VECS[v]);
            for (int k = 0; k < int'(VECS[v].nreq); k++)
                xfer(int'(VECS[v].stall), k == 1);
        end

        // R9: reset during a transfer returns to idle
        load_desc(VECS[0]);
        @(negedge clk) req = 1'b1;
        @(negedge clk) req = 1'b0;
        chk(mem_valid, "R9", "transfer started", {31'd0, mem_valid}, 32'd1);
        rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        chk(!busy && !mem_valid, "R9", "reset mid-transfer", {30'd0, busy, mem_valid}, 32'd0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule